// File: doc/BRIEF.md
# DMA trigger source selector

This block sits in front of four DMA channels and decides when each one starts. Every channel owns one 8-bit register on a small register bus. The register holds a six-bit source number and a pending-request flag. The source number picks one of 64 peripheral interrupt request lines. A rising edge on the chosen line sets the flag, whether or not the channel is enabled. A channel whose flag is set and whose enable is high receives a one-cycle start pulse, and the flag drops in that same cycle. Software may clear the flag but can never set it. Edges that arrive while the device is in standby are lost.

Each channel runs a four-state machine that tracks two things: whether a request is pending, and whether the source field may be rewritten. The states are CFG_IDLE (field writable, nothing pending), CFG_PEND (field writable, request pending), RUN_IDLE (field locked, nothing pending) and RUN_PEND (field locked, request pending). The transitions have these names:
- HIT: a new request sets the flag.
- CLEAR: a software clear drops the flag.
- LAUNCH: the start pulse is issued and the field is locked.
- TERMCNT: terminal count reopens the field.
- INIT: a channel initialize reopens the field and drops the flag.

When two transitions fall in one cycle, INIT is applied before LAUNCH, and LAUNCH before TERMCNT. A HIT in the same cycle always leaves the flag set.

Top module: `dma_trig_sel`

## Requirements
- R1: After reset all four channel registers read 0x00 and no start pulse is driven.
- R2: Channel n's register is at even address 2n. Bit 7 is the pending flag, bit 6 always reads 0, and bits 5..0 are the source number. Odd addresses read 0x00, and writes to odd addresses change nothing.
- R3: A line counts as rising when it was 0 in the previous cycle and is 1 now. When the line whose index equals a nonzero source number rises, the pending flag is set at the next clock edge, whatever the enable. Source 0 never sets the flag, and a line that stays high sets it only once.
- R4: start_o[n] is high in exactly those cycles in which the flag is set and ch_en_i[n] is high. This includes a flag that was already pending when the enable rises. After that edge the flag reads 0, unless R7 applies.
- R5: A write with wmask bit 7 = 1 and wdata bit 7 = 0 clears the flag. A write with wdata bit 7 = 1 leaves the flag unchanged.
- R6: A write changes only the bits whose wmask bit is 1. A flag-only write (mask 0x80) leaves the source number unchanged.
- R7: A new request in the same cycle as a software clear, a start pulse or an initialize leaves the flag set.
- R8: When standby_i is high, rising edges in that cycle neither set the flag nor cause a start.
- R9: The source field accepts writes only while the channel is in a CFG state and ch_en_i[n] is low. A CFG state holds after reset, after ch_init_i, and after ch_tc_i. A start pulse moves the channel to a RUN state, unless an initialize comes in the same cycle.
- R10: ch_init_i[n] clears channel n's pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 64 | Peripheral interrupt request lines |
| ch_en_i | input | 4 | Per-channel DMA enable |
| ch_init_i | input | 4 | Per-channel initialize pulse |
| ch_tc_i | input | 4 | Per-channel terminal-count pulse |
| standby_i | input | 1 | Device is in a standby mode |
| reg_addr_i | input | 3 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_wmask_i | input | 8 | Per-bit write enable |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| start_o | output | 4 | One-cycle transfer start per channel |

## Verification
The functions that can collide are a new request (HIT) and the flag-dropping paths, software CLEAR and LAUNCH, within one cycle. The bench raises the selected line in the same cycle as a flag-clearing write. It also raises the line again in the cycle the enable goes high, so that a start pulse and a new edge coincide. A behavioural model rules that the new request wins. The bench checks at the ports that the flag still reads 1 and that a second start pulse follows in the next cycle.

// File: rtl/dts_pkg.sv
package dts_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_BIT = 7;

    typedef enum logic [1:0] {
        CFG_IDLE = 2'b00,
        CFG_PEND = 2'b01,
        RUN_IDLE = 2'b10,
        RUN_PEND = 2'b11
    } ch_state_t;
endpackage

// File: rtl/dts_edge.sv
module dts_edge #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines_i;
    end

    assign rise_o = lines_i & ~prev_q;
endmodule

// File: rtl/dts_chan.sv
module dts_chan
    import dts_pkg::*;
#(
    parameter int SRC_N = 64,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] rise_i,
    input  logic             en_i,
    input  logic             init_i,
    input  logic             tc_i,
    input  logic             standby_i,
    input  logic             wr_i,
    input  logic             wflag_i,
    input  logic             mflag_i,
    input  logic [SEL_W-1:0] wsel_i,
    input  logic [SEL_W-1:0] msel_i,
    output logic             start_o,
    output logic             flag_o,
    output logic             open_o,
    output logic             hit_o,
    output logic [SEL_W-1:0] sel_o
);
    ch_state_t        state, nxt;
    logic [SEL_W-1:0] sel_q;
    logic             sw_clr;
    logic             launch;

    // request from the selected line, blocked in standby and for source 0
    assign hit_o  = (sel_q != '0) && rise_i[sel_q] && !standby_i;
    assign sw_clr = wr_i && mflag_i && !wflag_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CFG_IDLE;
        else        state <= nxt;
    end

    // outputs decoded from the state
    always_comb begin
        flag_o = 1'b0;
        open_o = 1'b1;
        unique case (state)
            CFG_IDLE: begin flag_o = 1'b0; open_o = 1'b1; end
            CFG_PEND: begin flag_o = 1'b1; open_o = 1'b1; end
            RUN_IDLE: begin flag_o = 1'b0; open_o = 1'b0; end
            RUN_PEND: begin flag_o = 1'b1; open_o = 1'b0; end
            default:  begin flag_o = 1'b0; open_o = 1'b1; end
        endcase
    end

    assign launch  = flag_o && en_i;
    assign start_o = launch;

    // next state: INIT > LAUNCH > TERMCNT > CLEAR, HIT keeps the flag
    always_comb begin
        nxt = state;
        unique case (state)
            CFG_IDLE: begin
                if (hit_o) nxt = CFG_PEND;
            end
            CFG_PEND: begin
                if (init_i)                nxt = hit_o ? CFG_PEND : CFG_IDLE;
                else if (launch)           nxt = hit_o ? RUN_PEND : RUN_IDLE;
                else if (sw_clr && !hit_o) nxt = CFG_IDLE;
            end
            RUN_IDLE: begin
                if (init_i || tc_i)        nxt = hit_o ? CFG_PEND : CFG_IDLE;
                else if (hit_o)            nxt = RUN_PEND;
            end
            RUN_PEND: begin
                if (init_i)                nxt = hit_o ? CFG_PEND : CFG_IDLE;
                else if (launch)           nxt = hit_o ? RUN_PEND : RUN_IDLE;
                else if (tc_i)             nxt = (sw_clr && !hit_o) ? CFG_IDLE : CFG_PEND;
                else if (sw_clr && !hit_o) nxt = RUN_IDLE;
            end
            default: nxt = CFG_IDLE;
        endcase
    end

    // source field: masked write only inside the configuration window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_i && open_o && !en_i) begin
            sel_q <= (sel_q & ~msel_i) | (wsel_i & msel_i);
        end
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/dts_regif.sv
module dts_regif
    import dts_pkg::*;
#(
    parameter int CH_N   = 4,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  we_i,
    input  logic [CH_N*REG_W-1:0] rd_flat_i,
    output logic [CH_N-1:0]       wr_sel_o,
    output logic [REG_W-1:0]      rdata_o
);
    localparam int CH_W = ADDR_W - 1;

    logic [CH_W-1:0] ch;
    logic            valid;

    assign ch    = addr_i[ADDR_W-1:1];
    assign valid = !addr_i[0] && (int'(ch) < CH_N);

    always_comb begin
        wr_sel_o = '0;
        rdata_o  = '0;
        if (valid) begin
            wr_sel_o[ch] = we_i;
            rdata_o      = rd_flat_i[int'(ch)*REG_W +: REG_W];
        end
    end
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
    import dts_pkg::*;
#(
    parameter  int CH_N   = 4,
    parameter  int SRC_N  = 64,
    localparam int SEL_W  = $clog2(SRC_N),
    localparam int ADDR_W = $clog2(2 * CH_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  irq_i,
    input  logic [CH_N-1:0]   ch_en_i,
    input  logic [CH_N-1:0]   ch_init_i,
    input  logic [CH_N-1:0]   ch_tc_i,
    input  logic              standby_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic [REG_W-1:0]  reg_wmask_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic [CH_N-1:0]   start_o
);
    logic [SRC_N-1:0]      rise_w;
    logic [CH_N-1:0]       wr_sel;
    logic [CH_N-1:0]       flag_w;
    logic [CH_N-1:0]       open_w;
    logic [CH_N-1:0]       hit_w;
    logic [CH_N*SEL_W-1:0] sel_w;
    logic [CH_N*REG_W-1:0] rd_flat;
    logic                  unused_bits;

    // bit 6 and any bits above the source field are never stored
    assign unused_bits = ^{reg_wdata_i[REG_W-2:SEL_W], reg_wmask_i[REG_W-2:SEL_W]};

    dts_edge #(.N(SRC_N)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_i),
        .rise_o  (rise_w)
    );

    dts_regif #(.CH_N(CH_N), .ADDR_W(ADDR_W)) u_regif (
        .addr_i    (reg_addr_i),
        .we_i      (reg_we_i),
        .rd_flat_i (rd_flat),
        .wr_sel_o  (wr_sel),
        .rdata_o   (reg_rdata_o)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic [REG_W-1:0] rbyte;

        dts_chan #(.SRC_N(SRC_N), .SEL_W(SEL_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise_i    (rise_w),
            .en_i      (ch_en_i[c]),
            .init_i    (ch_init_i[c]),
            .tc_i      (ch_tc_i[c]),
            .standby_i (standby_i),
            .wr_i      (wr_sel[c]),
            .wflag_i   (reg_wdata_i[FLAG_BIT]),
            .mflag_i   (reg_wmask_i[FLAG_BIT]),
            .wsel_i    (reg_wdata_i[SEL_W-1:0]),
            .msel_i    (reg_wmask_i[SEL_W-1:0]),
            .start_o   (start_o[c]),
            .flag_o    (flag_w[c]),
            .open_o    (open_w[c]),
            .hit_o     (hit_w[c]),
            .sel_o     (sel_w[c*SEL_W +: SEL_W])
        );

        always_comb begin
            rbyte              = '0;
            rbyte[SEL_W-1:0]   = sel_w[c*SEL_W +: SEL_W];
            rbyte[FLAG_BIT]    = flag_w[c];
        end

        assign rd_flat[c*REG_W +: REG_W] = rbyte;
    end
endmodule

// File: rtl/dts_chk.sv
module dts_chk #(
    parameter int CH_N  = 4,
    parameter int SEL_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  standby_i,
    input logic [CH_N-1:0]       ch_en_i,
    input logic [CH_N-1:0]       start_o,
    input logic [CH_N-1:0]       flag_i,
    input logic [CH_N-1:0]       open_i,
    input logic [CH_N-1:0]       hit_i,
    input logic [CH_N*SEL_W-1:0] sel_i,
    input logic [7:0]            rdata_i
);
    a_r2_bit6_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_i[6] == 1'b0);

    for (genvar c = 0; c < CH_N; c++) begin : g_chk
        // R4: a start without a concurrent request leaves the flag clear
        a_r4_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (start_o[c] && !hit_i[c]) |=> !flag_i[c]);

        // R5: only a request can set the flag
        a_r5_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_i[c] && !hit_i[c]) |=> !flag_i[c]);

        // R7: a request always leaves the flag set
        a_r7_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[c] |=> flag_i[c]);

        // R8: standby blocks new requests
        a_r8_standby_no_set: assert property (@(posedge clk) disable iff (!rst_n)
            (standby_i && !flag_i[c]) |=> !flag_i[c]);

        // R3: source 0 never produces a request
        a_r3_src0_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i[c*SEL_W +: SEL_W] == '0) |-> !hit_i[c]);

        // R9: field frozen outside the window or while enabled
        a_r9_field_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (!open_i[c] || ch_en_i[c]) |=> $stable(sel_i[c*SEL_W +: SEL_W]));
    end
endmodule

bind dma_trig_sel dts_chk #(.CH_N(CH_N), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .ch_en_i   (ch_en_i),
    .start_o   (start_o),
    .flag_i    (flag_w),
    .open_i    (open_w),
    .hit_i     (hit_w),
    .sel_i     (sel_w),
    .rdata_i   (reg_rdata_o)
);

// File: tb/sim_dma_trig_sel.sv
module sim_dma_trig_sel;
    localparam int CH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] irq;
    logic [3:0]  en, init, tc;
    logic        standby;
    logic [2:0]  addr;
    logic        we;
    logic [7:0]  wdata, wmask;
    wire  [7:0]  rdata;
    wire  [3:0]  start;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    bit          mflag [CH];
    bit          mopen [CH];
    logic [5:0]  msel  [CH];
    logic [63:0] mprev;

    always #5 clk = ~clk;

    dma_trig_sel u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .ch_en_i(en), .ch_init_i(init),
        .ch_tc_i(tc), .standby_i(standby), .reg_addr_i(addr), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_wmask_i(wmask), .reg_rdata_o(rdata), .start_o(start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mread(input logic [2:0] a);
        int c;
        c = int'(a[2:1]);
        if (a[0]) return 8'h00;
        return {mflag[c], 1'b0, msel[c]};
    endfunction

    // compare on this cycle, advance the model, cross one clock
    task automatic step();
        logic [3:0]  es;
        logic [63:0] rise;
        #1;
        for (int c = 0; c < CH; c++) es[c] = mflag[c] & en[c];
        chk("R4 model start", start, es);
        chk("R2 model read", rdata, mread(addr));
        rise = irq & ~mprev;
        for (int c = 0; c < CH; c++) begin
            bit hit, wr, clr, launch;
            hit    = (msel[c] != 0) && rise[msel[c]] && !standby;
            wr     = we && (addr == 3'(2 * c));
            clr    = wr && wmask[7] && !wdata[7];
            launch = mflag[c] && en[c];
            if (wr && mopen[c] && !en[c])
                msel[c] = (msel[c] & ~wmask[5:0]) | (wdata[5:0] & wmask[5:0]);
            if (init[c])     mopen[c] = 1'b1;
            else if (launch) mopen[c] = 1'b0;
            else if (tc[c])  mopen[c] = 1'b1;
            if (hit)                        mflag[c] = 1'b1;
            else if (init[c] || clr || launch) mflag[c] = 1'b0;
        end
        mprev = irq;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] m);
        addr = a; wdata = d; wmask = m; we = 1'b1;
        step();
        we = 1'b0; wdata = 8'h00; wmask = 8'h00;
    endtask

    task automatic peek(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq = '0; en = '0; init = '0; tc = '0; standby = 1'b0;
        addr = '0; we = 1'b0; wdata = '0; wmask = '0;
        for (int c = 0; c < CH; c++) begin mflag[c] = 0; mopen[c] = 1; msel[c] = '0; end
        mprev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < CH; c++) peek("R1 reset value", 3'(2 * c), 8'h00);
        chk("R1 no start after reset", start, 4'h0);

        // R2 / R6 field layout and masked write
        wr(3'd0, 8'hFF, 8'h7F);
        peek("R2 bit6 reads zero", 3'd0, 8'h3F);
        wr(3'd0, 8'h05, 8'h3F);
        peek("R6 masked source write", 3'd0, 8'h05);
        wr(3'd2, 8'h3F, 8'h3F);
        wr(3'd6, 8'h01, 8'h3F);
        peek("R2 channel 1 at address 2", 3'd2, 8'h3F);

        // R3 request latches while disabled
        irq[5] = 1'b1; step(); irq[5] = 1'b0;
        peek("R3 flag set while disabled", 3'd0, 8'h85);
        chk("R4 no start while disabled", start[0], 1'b0);

        // R5 software cannot set, can clear
        wr(3'd2, 8'h80, 8'h80);
        peek("R5 write 1 has no effect", 3'd2, 8'h3F);
        wr(3'd0, 8'h00, 8'h80);
        peek("R5 flag cleared, R6 source kept", 3'd0, 8'h05);

        // R4 pending request fires when enable rises
        irq[5] = 1'b1; step(); irq[5] = 1'b0;
        en[0] = 1'b1;
        #1 chk("R4 start on enable", start[0], 1'b1);
        step();
        chk("R4 single pulse", start[0], 1'b0);
        peek("R4 flag auto cleared", 3'd0, 8'h05);
        en[0] = 1'b0;

        // R9 window locked after start, reopened by terminal count
        wr(3'd0, 8'h07, 8'h3F);
        peek("R9 locked after start", 3'd0, 8'h05);
        tc[0] = 1'b1; step(); tc[0] = 1'b0;
        wr(3'd0, 8'h07, 8'h3F);
        peek("R9 reopened by terminal count", 3'd0, 8'h07);
        en[0] = 1'b1;
        wr(3'd0, 8'h09, 8'h3F);
        peek("R9 locked while enabled", 3'd0, 8'h07);
        en[0] = 1'b0;

        // R3 source 0 silent, held line counts once
        irq = '1; step();
        peek("R3 source 0 never sets", 3'd4, 8'h00);
        peek("R3 source 63 sets", 3'd2, 8'hBF);
        wr(3'd2, 8'h00, 8'h80);
        step();
        peek("R3 held line does not re-set", 3'd2, 8'h3F);
        irq = '0;
        wr(3'd0, 8'h00, 8'h80);
        wr(3'd6, 8'h00, 8'h80);
        peek("R5 clear channel 3", 3'd6, 8'h01);

        // R8 standby swallows edges
        standby = 1'b1; irq[63] = 1'b1; step(); irq[63] = 1'b0;
        standby = 1'b0;
        peek("R8 standby edge ignored", 3'd2, 8'h3F);
        chk("R8 no start in standby", start, 4'h0);

        // R7 new request beats clear and start
        irq[1] = 1'b1;
        wr(3'd6, 8'h00, 8'h80);
        peek("R7 request beats clear", 3'd6, 8'h81);
        irq[1] = 1'b0; step();
        en[3] = 1'b1; irq[1] = 1'b1;
        #1 chk("R4 start channel 3", start[3], 1'b1);
        step();
        irq[1] = 1'b0;
        peek("R7 request beats start", 3'd6, 8'h81);
        chk("R7 second start follows", start[3], 1'b1);
        step();
        peek("R4 flag clears after start", 3'd6, 8'h01);
        chk("R4 start ends", start[3], 1'b0);
        en[3] = 1'b0;

        // R10 initialize clears and reopens
        irq[7] = 1'b1; step(); irq[7] = 1'b0;
        peek("R3 channel 0 source 7", 3'd0, 8'h87);
        init[0] = 1'b1; step(); init[0] = 1'b0;
        peek("R10 init clears flag", 3'd0, 8'h07);
        irq[7] = 1'b1; step(); irq[7] = 1'b0;
        en[0] = 1'b1; step(); en[0] = 1'b0;
        wr(3'd0, 8'h03, 8'h3F);
        peek("R9 locked after second start", 3'd0, 8'h07);
        init[0] = 1'b1; step(); init[0] = 1'b0;
        wr(3'd0, 8'h03, 8'h3F);
        peek("R10 init reopens field", 3'd0, 8'h03);

        // R2 odd address
        wr(3'd1, 8'hFF, 8'hFF);
        peek("R2 odd write ignored", 3'd0, 8'h03);
        peek("R2 odd address reads zero", 3'd1, 8'h00);
        step();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule